// File: doc/BRIEF.md
# Parallel-Bus Reader for an Eight-Channel Simultaneous-Sampling Converter

This controller sits on the host side of an 18-bit converter that samples eight channels at once and returns its results over a 16-bit parallel bus. When a start request arrives and the converter is idle, the controller pulses the conversion-start line. It then waits for the converter's busy line to rise and fall again. After that it frames a read burst with chip select and issues two read strobes per channel, for sixteen strobes in all.

Each channel's 18-bit result comes back split across two bus words. The first word carries the upper sixteen result bits. The top two bus bits of the second word carry the two lowest result bits. The controller merges the two words and presents all eight results together with a one-cycle valid pulse. On the first strobe of every channel it samples the converter's first-channel flag to confirm that the channel order has not slipped. A busy line that does not rise, or that does not fall, within a bounded number of clocks ends the attempt with a reset pulse to the converter. All bus timing is counted in system clocks.

Top module: `adcrd_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cnv_o`=0, `cs_n_o`=1, `rd_n_o`=1, `adc_rst_o`=0, `valid_o`=0, `align_err_o`=0 and `data_o`=0.
- R2: A conversion starts only in a cycle where `start_i`=1, `busy_i`=0 and the controller is idle. `cnv_o` is then high for exactly CNV_W cycles. A `start_i` held high while a conversion or read is in progress causes no extra pulse.
- R3: `cs_n_o` falls only after `busy_i` has risen and then fallen following the start pulse.
- R4: `rd_n_o` is low only while `cs_n_o` is low. `cs_n_o` falls CS_SETUP cycles before the first strobe falls. It rises RD_HIGH+CS_HOLD cycles after the last strobe rises.
- R5: Each read strobe is low for exactly RD_LOW cycles. Strobes within a burst are separated by exactly RD_HIGH high cycles.
- R6: Each burst has exactly 2×CHANNELS strobes, read in channel order. Bus word 2n supplies result bits [17:2] of channel n from `db_i[15:0]`. Bus word 2n+1 supplies result bits [1:0] from `db_i[15:14]`. `db_i[13:0]` of the second word has no effect on the result.
- R7: `valid_o` is high for exactly one cycle, the cycle after `cs_n_o` rises at the end of a burst. `data_o[18n+17:18n]` holds channel n. `data_o` changes only with `valid_o`.
- R8: `frst_i` is sampled in the last low cycle of each channel's first strobe. It must be 1 for channel 0 and 0 for every other channel. `align_err_o` is 1 if any sample in the burst broke this rule, is updated only with `valid_o`, and holds until the next valid.
- R9: If `busy_i` does not rise, or does not fall, within BUSY_TIMEOUT cycles, `adc_rst_o` is high for exactly RST_W cycles. No strobe is issued, no `valid_o` follows, and `data_o` is kept.
- R10: Two rising edges of `cnv_o` are never closer than CYCLE_MIN cycles. With `start_i` held high and a short burst, they are exactly CYCLE_MIN cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for a conversion and read |
| busy_i | input | 1 | Converter busy indication |
| db_i | input | 16 | Converter parallel data bus |
| frst_i | input | 1 | Converter first-channel flag |
| cnv_o | output | 1 | Conversion start, drives both start inputs |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| adc_rst_o | output | 1 | Reset pulse to the converter after a busy timeout |
| data_o | output | 144 | Eight merged 18-bit results, channel 0 in the low bits |
| valid_o | output | 1 | One-cycle pulse when `data_o` is updated |
| align_err_o | output | 1 | First-channel flag mismatch seen in the last burst |

## Verification
Two events can fall in the same cycle, and both are provoked and judged against the bench model. The first is a start request held high while the busy-spacing window expires: the bench keeps `start_i` asserted across two frames and requires the next start pulse to land exactly CYCLE_MIN cycles after the previous one, with no pulse while busy is high. The second is the closing of a burst, where the strobe that carries channel 7's low bits is followed by the chip-select release and then the valid pulse. In that burst the bench drives nonzero filler on the unused low bus bits and, in one frame, a first-channel flag that stays high into channel 1. It then checks the merged data and the error flag in the exact valid cycle.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int SAMPLE_W = 18;
  localparam int BUS_W    = 16;
  localparam int LOW_W    = SAMPLE_W - BUS_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CONV, ST_WAIT_HI, ST_WAIT_LO, ST_SETUP,
    ST_RD_LO, ST_RD_HI, ST_HOLD, ST_DONE, ST_ABORT
  } seq_state_e;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Merge one bus word into a channel accumulator.
  // First word: upper result bits; second word: low bits from the bus top.
  function automatic logic [SAMPLE_W-1:0] merge_word(
      logic [SAMPLE_W-1:0] acc, logic [BUS_W-1:0] word, logic second);
    if (!second) return {word, acc[LOW_W-1:0]};
    return {acc[SAMPLE_W-1:LOW_W], word[BUS_W-1 -: LOW_W]};
  endfunction
endpackage

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int CHANNELS     = 8,
  parameter int CNV_W        = 3,
  parameter int CS_SETUP     = 2,
  parameter int RD_LOW       = 3,
  parameter int RD_HIGH      = 2,
  parameter int CS_HOLD      = 2,
  parameter int BUSY_TIMEOUT = 40000,
  parameter int CYCLE_MIN    = 500,
  parameter int RST_W        = 12,
  localparam int STROBES     = 2 * CHANNELS,
  localparam int SW          = $clog2(STROBES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          busy_i,
  output logic          cnv_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic          adc_rst_o,
  output logic          ev_start,
  output logic          ev_take,
  output logic [SW-1:0] take_idx,
  output logic          ev_done
);
  localparam int MAXC = max_of(max_of(max_of(CNV_W, CS_SETUP), max_of(RD_LOW, RD_HIGH)),
                               max_of(max_of(CS_HOLD, BUSY_TIMEOUT), RST_W));
  localparam int CW = $clog2(MAXC + 1);
  localparam int GW = $clog2(CYCLE_MIN + 1);
  localparam logic [SW-1:0] LAST_IDX = SW'(STROBES - 1);

  seq_state_e      st;
  logic [CW-1:0]   cnt;
  logic [GW-1:0]   gap;
  logic [SW-1:0]   sidx;
  logic            cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign ev_start = (st == ST_IDLE) && start_i && !busy_i && (gap == '0);
  assign ev_take  = (st == ST_RD_LO) && cnt_zero;
  assign ev_done  = (st == ST_DONE);
  assign take_idx = sidx;

  assign cnv_o     = (st == ST_CONV);
  assign rd_n_o    = (st != ST_RD_LO);
  assign cs_n_o    = !((st == ST_SETUP) || (st == ST_RD_LO) ||
                       (st == ST_RD_HI) || (st == ST_HOLD));
  assign adc_rst_o = (st == ST_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      gap  <= '0;
      sidx <= '0;
    end else begin
      if (gap != '0) gap <= gap - GW'(1);
      unique case (st)
        ST_IDLE: if (ev_start) begin
          st  <= ST_CONV;
          cnt <= CW'(CNV_W - 1);
          gap <= GW'(CYCLE_MIN - 1);
        end
        ST_CONV: if (cnt_zero) begin
          st  <= ST_WAIT_HI;
          cnt <= CW'(BUSY_TIMEOUT - 1);
        end else cnt <= cnt - CW'(1);
        ST_WAIT_HI: if (busy_i) begin
          st  <= ST_WAIT_LO;
          cnt <= CW'(BUSY_TIMEOUT - 1);
        end else if (cnt_zero) begin
          st  <= ST_ABORT;
          cnt <= CW'(RST_W - 1);
        end else cnt <= cnt - CW'(1);
        ST_WAIT_LO: if (!busy_i) begin
          st  <= ST_SETUP;
          cnt <= CW'(CS_SETUP - 1);
        end else if (cnt_zero) begin
          st  <= ST_ABORT;
          cnt <= CW'(RST_W - 1);
        end else cnt <= cnt - CW'(1);
        ST_SETUP: if (cnt_zero) begin
          st   <= ST_RD_LO;
          cnt  <= CW'(RD_LOW - 1);
          sidx <= '0;
        end else cnt <= cnt - CW'(1);
        ST_RD_LO: if (cnt_zero) begin
          st  <= ST_RD_HI;
          cnt <= CW'(RD_HIGH - 1);
        end else cnt <= cnt - CW'(1);
        ST_RD_HI: if (cnt_zero) begin
          if (sidx == LAST_IDX) begin
            st  <= ST_HOLD;
            cnt <= CW'(CS_HOLD - 1);
          end else begin
            st   <= ST_RD_LO;
            cnt  <= CW'(RD_LOW - 1);
            sidx <= sidx + SW'(1);
          end
        end else cnt <= cnt - CW'(1);
        ST_HOLD: if (cnt_zero) st <= ST_DONE;
          else cnt <= cnt - CW'(1);
        ST_DONE: st <= ST_IDLE;
        ST_ABORT: if (cnt_zero) st <= ST_IDLE;
          else cnt <= cnt - CW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcrd_assemble.sv
module adcrd_assemble
  import adcrd_pkg::*;
#(
  parameter int CHANNELS = 8,
  localparam int SW      = $clog2(2 * CHANNELS),
  localparam int OUT_W   = CHANNELS * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_take,
  input  logic [SW-1:0]    take_idx,
  input  logic             ev_done,
  input  logic [BUS_W-1:0] db_i,
  input  logic             frst_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o,
  output logic             align_err_o,
  output logic             ev_misalign
);
  logic [OUT_W-1:0] work_flat;
  logic             err_acc;

  // Flag must be high exactly on the first word of channel 0.
  assign ev_misalign = ev_take && !take_idx[0] &&
                       (frst_i != (take_idx[SW-1:1] == '0));

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] acc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else if (ev_take && (take_idx[SW-1:1] == (SW-1)'(ch)))
        acc <= merge_word(acc, db_i, take_idx[0]);
    end
    assign work_flat[ch*SAMPLE_W +: SAMPLE_W] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc     <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      valid_o <= ev_done;
      if (ev_start) err_acc <= 1'b0;
      else if (ev_misalign) err_acc <= 1'b1;
      if (ev_done) begin
        data_o      <= work_flat;
        align_err_o <= err_acc;
      end
    end
  end
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int CHANNELS     = 8,
  parameter int CNV_W        = 3,
  parameter int CS_SETUP     = 2,
  parameter int RD_LOW       = 3,
  parameter int RD_HIGH      = 2,
  parameter int CS_HOLD      = 2,
  parameter int BUSY_TIMEOUT = 40000,
  parameter int CYCLE_MIN    = 500,
  parameter int RST_W        = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           busy_i,
  input  logic [BUS_W-1:0]               db_i,
  input  logic                           frst_i,
  output logic                           cnv_o,
  output logic                           cs_n_o,
  output logic                           rd_n_o,
  output logic                           adc_rst_o,
  output logic [CHANNELS*SAMPLE_W-1:0]   data_o,
  output logic                           valid_o,
  output logic                           align_err_o
);
  localparam int SW = $clog2(2 * CHANNELS);

  logic          ev_start;
  logic          ev_take;
  logic [SW-1:0] take_idx;
  logic          ev_done;
  logic          ev_misalign;

  adcrd_seq #(
    .CHANNELS(CHANNELS), .CNV_W(CNV_W), .CS_SETUP(CS_SETUP),
    .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH), .CS_HOLD(CS_HOLD),
    .BUSY_TIMEOUT(BUSY_TIMEOUT), .CYCLE_MIN(CYCLE_MIN), .RST_W(RST_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .cnv_o(cnv_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .adc_rst_o(adc_rst_o),
    .ev_start(ev_start), .ev_take(ev_take), .take_idx(take_idx), .ev_done(ev_done)
  );

  adcrd_assemble #(.CHANNELS(CHANNELS)) u_asm (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_take(ev_take),
    .take_idx(take_idx), .ev_done(ev_done), .db_i(db_i), .frst_i(frst_i),
    .data_o(data_o), .valid_o(valid_o), .align_err_o(align_err_o),
    .ev_misalign(ev_misalign)
  );
endmodule

// File: rtl/adcrd_chk.sv
module adcrd_chk #(
  parameter int CHANNELS  = 8,
  parameter int RD_LOW    = 3,
  parameter int RST_W     = 12,
  parameter int CYCLE_MIN = 500
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic busy_i,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic valid_o,
  input logic adc_rst_o,
  input logic ev_take
);
  int   lo_cnt, rst_cnt, take_cnt, since;
  logic cnv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= 0;
      rst_cnt  <= 0;
      take_cnt <= 0;
      since    <= CYCLE_MIN;
      cnv_d    <= 1'b0;
    end else begin
      lo_cnt   <= rd_n_o ? 0 : lo_cnt + 1;
      rst_cnt  <= adc_rst_o ? rst_cnt + 1 : 0;
      take_cnt <= (valid_o || adc_rst_o) ? 0 : take_cnt + (ev_take ? 1 : 0);
      cnv_d    <= cnv_o;
      since    <= (cnv_o && !cnv_d) ? 1 : ((since < CYCLE_MIN) ? since + 1 : since);
    end
  end

  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !$past(busy_i));

  p_rd_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !cs_n_o);

  p_rd_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_o) |-> (lo_cnt == RD_LOW));

  p_all_words_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (take_cnt == 2 * CHANNELS));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_reset_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rst_o) |-> (rst_cnt == RST_W));

  p_start_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> (since >= CYCLE_MIN));
endmodule

bind adcrd_ctrl adcrd_chk #(
  .CHANNELS(CHANNELS), .RD_LOW(RD_LOW), .RST_W(RST_W), .CYCLE_MIN(CYCLE_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .busy_i(busy_i), .cs_n_o(cs_n_o),
  .rd_n_o(rd_n_o), .valid_o(valid_o), .adc_rst_o(adc_rst_o), .ev_take(ev_take)
);

// File: tb/adcrd_ctrl_tb.sv
module adcrd_ctrl_tb;
  localparam int CLK_P     = 10;
  localparam int CH        = 8;
  localparam int CNV_W     = 2;
  localparam int CS_SETUP  = 2;
  localparam int RD_LOW    = 2;
  localparam int RD_HIGH   = 3;
  localparam int CS_HOLD   = 1;
  localparam int TMO       = 40;
  localparam int CYCLE_MIN = 120;
  localparam int RST_W     = 3;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_i, frst_i;
  logic [15:0] db_i;
  logic cnv_o, cs_n_o, rd_n_o, adc_rst_o, valid_o, align_err_o;
  logic [CH*18-1:0] data_o;

  always #(CLK_P/2) clk = ~clk;

  adcrd_ctrl #(
    .CHANNELS(CH), .CNV_W(CNV_W), .CS_SETUP(CS_SETUP), .RD_LOW(RD_LOW),
    .RD_HIGH(RD_HIGH), .CS_HOLD(CS_HOLD), .BUSY_TIMEOUT(TMO),
    .CYCLE_MIN(CYCLE_MIN), .RST_W(RST_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i), .db_i(db_i),
    .frst_i(frst_i), .cnv_o(cnv_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .adc_rst_o(adc_rst_o), .data_o(data_o), .valid_o(valid_o),
    .align_err_o(align_err_o)
  );

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural converter model and timing observer
  logic [17:0] samp [CH];
  int  busy_len = 10, busy_cnt = 0, busy_dly = 0;
  bit  stuck = 0, bad_flag = 0, m_busy = 0, busy_seen = 0;
  int  k = 0, falls = 0, cyc = 0, last_rise = -1, last_space = 0;
  int  cnv_run = 0, rd_run = 0, rst_run = 0, since_cs = 0, since_rd = 0;
  int  valid_cnt = 0, csfall_cnt = 0;
  bit  arm = 0, exp_v;
  logic cnv_p = 0, rd_p = 1, cs_p = 1, rst_p = 0;

  function automatic logic [15:0] word_at(int idx);
    int ch;
    ch = idx / 2;
    if (idx >= 2 * CH) return 16'h0000;
    if (idx % 2 == 0) return samp[ch][17:2];
    return {samp[ch][1:0], 14'h2A5B};
  endfunction

  assign busy_i = m_busy;
  assign db_i   = (!cs_n_o && !rd_n_o) ? word_at(k) : 16'hFFFF;
  assign frst_i = !cs_n_o && ((falls >= 1 && falls <= 2) ||
                              (bad_flag && falls >= 3 && falls <= 4));

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; busy_dly = 0; k = 0; falls = 0; arm = 0;
      cnv_p = 0; rd_p = 1; cs_p = 1; rst_p = 0;
    end else begin
      cyc++; since_cs++; since_rd++;
      if (cnv_o && !cnv_p) begin
        chk(!m_busy, "R2", "start pulse while busy", int'(m_busy), 0);
        if (last_rise >= 0) begin
          last_space = cyc - last_rise;
          chk(last_space >= CYCLE_MIN, "R10", "start spacing", last_space, CYCLE_MIN);
        end
        last_rise = cyc; k = 0; falls = 0; busy_dly = 2; busy_seen = 0;
      end
      if (!cnv_o && cnv_p) chk(cnv_run == CNV_W, "R2", "start pulse width", cnv_run, CNV_W);
      cnv_run = cnv_o ? cnv_run + 1 : 0;
      if (adc_rst_o) begin
        m_busy = 0; busy_dly = 0;
      end else if (busy_dly > 0) begin
        busy_dly--;
        if (busy_dly == 0) begin m_busy = 1; busy_seen = 1; busy_cnt = busy_len; end
      end else if (m_busy && !stuck) begin
        busy_cnt--;
        if (busy_cnt == 0) m_busy = 0;
      end
      if (!adc_rst_o && rst_p) chk(rst_run == RST_W, "R9", "reset pulse width", rst_run, RST_W);
      rst_run = adc_rst_o ? rst_run + 1 : 0;
      if (!rd_n_o) chk(!cs_n_o, "R4", "strobe outside select", int'(cs_n_o), 0);
      if (!rd_n_o && rd_p) begin
        falls++;
        if (k == 0) chk(since_cs == CS_SETUP, "R4", "select setup", since_cs, CS_SETUP);
        else chk(rd_run == RD_HIGH, "R5", "strobe high width", rd_run, RD_HIGH);
      end
      if (rd_n_o && !rd_p) begin
        chk(rd_run == RD_LOW, "R5", "strobe low width", rd_run, RD_LOW);
        k++; since_rd = 0;
      end
      rd_run = (rd_n_o == rd_p) ? rd_run + 1 : 1;
      if (!cs_n_o && cs_p) begin
        chk(busy_seen && !m_busy, "R3", "select before busy done", int'(m_busy), 0);
        since_cs = 0; csfall_cnt++;
      end
      exp_v = arm;
      arm = 0;
      if (cs_n_o && !cs_p) begin
        chk(k == 2 * CH, "R6", "strobes per burst", k, 2 * CH);
        chk(since_rd == RD_HIGH + CS_HOLD, "R4", "select hold", since_rd, RD_HIGH + CS_HOLD);
        arm = 1;
      end
      if (valid_o || exp_v) chk(valid_o == exp_v, "R7", "valid timing", int'(valid_o), int'(exp_v));
      if (valid_o) begin
        valid_cnt++;
        for (int c = 0; c < CH; c++)
          chk(data_o[c*18 +: 18] == samp[c], "R6", $sformatf("channel %0d result", c),
              int'(data_o[c*18 +: 18]), int'(samp[c]));
        chk(align_err_o == bad_flag, "R8", "alignment flag", int'(align_err_o), int'(bad_flag));
      end
      cnv_p = cnv_o; rd_p = rd_n_o; cs_p = cs_n_o; rst_p = adc_rst_o;
    end
  end

  task automatic wait_valid();
    int n0;
    bit ok;
    n0 = valid_cnt; ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (valid_cnt != n0) begin ok = 1; break; end
    end
    chk(ok, "R7", "frame completed", int'(ok), 1);
  endtask

  task automatic run_frame(int blen, bit bad);
    busy_len = blen; bad_flag = bad; stuck = 0;
    @(negedge clk); start_i = 1;
    wait (cnv_o == 1'b1);
    @(negedge clk); start_i = 0;
    wait_valid();
  endtask

  task automatic check_idle_outputs(string tag);
    chk(cnv_o == 0 && cs_n_o == 1 && rd_n_o == 1 && adc_rst_o == 0, "R1",
        {tag, " control pins"}, int'({cnv_o, cs_n_o, rd_n_o, adc_rst_o}), 4'b0110);
    chk(valid_o == 0 && align_err_o == 0, "R1", {tag, " status"},
        int'({valid_o, align_err_o}), 0);
    chk(data_o == '0, "R1", {tag, " data"}, int'(data_o[31:0]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [CH*18-1:0] held;
    int vc, cf;
    bit ok;
    for (int c = 0; c < CH; c++) samp[c] = '0;
    repeat (3) @(negedge clk);
    check_idle_outputs("in reset");
    rst_n = 1;
    @(negedge clk);
    check_idle_outputs("after reset");

    // ramp pattern
    for (int c = 0; c < CH; c++) samp[c] = 18'(c * 32'h4D2B + 32'h101);
    run_frame(10, 0);
    // extremes alternating
    for (int c = 0; c < CH; c++) samp[c] = (c % 2 == 0) ? 18'h3FFFF : 18'h00000;
    run_frame(4, 0);
    // walking bits touching both low bits
    for (int c = 0; c < CH; c++) samp[c] = (18'h1 << (c * 2 + 1)) | 18'h1;
    run_frame(5, 0);
    // pseudo-random
    seed = 32'h1F2E3D4C;
    for (int c = 0; c < CH; c++) begin
      seed = seed * 1103515245 + 12345;
      samp[c] = seed[25:8];
    end
    run_frame(20, 0);
    // flag still high on channel 1 first word, then a clean frame
    run_frame(7, 1);
    run_frame(7, 0);

    // busy never falls: timeout path
    held = data_o; vc = valid_cnt; cf = csfall_cnt;
    stuck = 1;
    @(negedge clk); start_i = 1;
    wait (cnv_o == 1'b1);
    @(negedge clk); start_i = 0;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (adc_rst_o) begin ok = 1; break; end
    end
    chk(ok, "R9", "reset pulse after timeout", int'(ok), 1);
    repeat (40) @(negedge clk);
    chk(valid_cnt == vc, "R9", "no valid after timeout", valid_cnt, vc);
    chk(csfall_cnt == cf, "R9", "no select after timeout", csfall_cnt, cf);
    chk(data_o == held, "R9", "data kept", int'(data_o[31:0]), int'(held[31:0]));
    stuck = 0;

    // held request: back-to-back starts exactly CYCLE_MIN apart
    for (int c = 0; c < CH; c++) samp[c] = 18'(32'h2AAAA ^ (c * 32'h1357));
    busy_len = 8; bad_flag = 0;
    @(negedge clk); start_i = 1;
    wait_valid();
    wait_valid();
    start_i = 0;
    chk(last_space == CYCLE_MIN, "R10", "held-request spacing", last_space, CYCLE_MIN);
    repeat (10) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule